// File: doc/BRIEF.md
# Packed Double-to-Half Masked Converter

This block narrows up to eight IEEE double-precision values, packed in a 512-bit source word, into IEEE half-precision results packed in a 128-bit word. A length select picks whether two, four or eight lanes are converted. Each lane is rounded in one of four directions. The rounding direction comes either from a per-operation field or from a global control word, depending on how the operation was issued. Inputs that are subnormal can be treated as zero under a global control bit. Results that are subnormal are always delivered as they are.

A lane mask controls which lanes are written. A lane that is switched off either takes its previous value from a merge input or is cleared. A broadcast mode feeds element 0 to every lane. The result and the five exception flags are registered, so they appear one clock after the inputs. The flags are the OR of the flags raised by all active lanes.

Top module: `fp64_to_fp16_pack`

## Requirements
- R1: `vlen_sel` selects how many lanes are active: 2'b00 gives lanes 0..1, 2'b01 gives lanes 0..3, and 2'b10 or 2'b11 give lanes 0..7. Lane j reads `src[64*j+63:64*j]` and writes `res[16*j+15:16*j]`.
- R2: The rounding mode is taken from `emb_rc` only when `src_is_mem` is 0, `vlen_sel[1]` is 1 and `bcast` is 1. In every other case it is taken from `glob_rc`.
- R3: When `src_is_mem` and `bcast` are both 1, every active lane converts `src[63:0]`. When either is 0, each lane converts its own element.
- R4: A lane is active when `mask_en` is 0, or when its bit in `lane_mask` is 1. An active in-range lane receives its converted value. An inactive in-range lane receives 16'h0000 when `zero_mode` is 1, and the matching 16 bits of `merge_in` otherwise.
- R5: All result bits above 16 times the active lane count are 0.
- R6: Every double that holds an exact half value converts to that value with no flag raised. This covers zeros, subnormals, normals and infinities, with the sign kept.
- R7: When the result is inexact it is rounded by the selected mode, and the Precision flag is set. The mode codes are: 2'b00 round to nearest with ties to even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, 2'b11 toward zero.
- R8: When a value is too large for half precision, the lane gives either infinity or the largest finite magnitude 15'h7BFF, with the sign applied. Infinity is given for round to nearest, and for a rounding direction that points away from zero on that sign. Overflow and Precision are both set.
- R9: A subnormal double input always sets Denormal. When `daz` is 1, the input becomes a zero of the same sign. When `daz` is 0, it rounds to zero or to the smallest subnormal according to the mode, and Underflow and Precision are set. Underflow is set when the exponent is below the smallest normal half exponent before rounding and the result is inexact.
- R10: A NaN input gives a quiet half NaN, made of the sign, 5'h1F, a 1, and source mantissa bits 50..42. A signalling NaN input (mantissa bit 51 = 0) sets Invalid.
- R11: `flags` is {Precision, Underflow, Overflow, Denormal, Invalid}, from bit 4 down to bit 0. It is the OR over the active in-range lanes. Inactive lanes and out-of-range lanes raise nothing.
- R12: `res` and `flags` change on the clock after the inputs they reflect. While `rst_n` is low, both are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 512 | Eight packed double values |
| vlen_sel | input | 2 | Lane count select |
| lane_mask | input | 8 | Per-lane write enables |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1 = clear inactive lanes, 0 = merge |
| bcast | input | 1 | Broadcast / per-operation rounding bit |
| src_is_mem | input | 1 | Source came from memory |
| emb_rc | input | 2 | Per-operation rounding mode |
| glob_rc | input | 2 | Global rounding mode |
| daz | input | 1 | Treat subnormal inputs as zero |
| merge_in | input | 128 | Previous destination value |
| res | output | 128 | Packed half-precision result |
| flags | output | 5 | Exception flags of the operation |

## Verification
The only state in the block is its output register. Any fault in the lane logic therefore shows up on `res` or `flags` exactly one clock after the stimulus that exposes it. Nothing is hidden that could surface later. A wrong choice of rounding source, broadcast element or mask action changes specific 16-bit fields at that next edge. A fault in the rounding or exponent logic shows as a one-unit error in the last place or as a wrong flag bit for particular input values. For that reason, the bench sweeps every half value, plus three offsets around each normal value, under all four rounding modes.

// File: rtl/fp64_to_fp16_pack.sv
module fp64_to_fp16_pack #(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*64-1:0]   src,
  input  logic [1:0]            vlen_sel,
  input  logic [LANES-1:0]      lane_mask,
  input  logic                  mask_en,
  input  logic                  zero_mode,
  input  logic                  bcast,
  input  logic                  src_is_mem,
  input  logic [1:0]            emb_rc,
  input  logic [1:0]            glob_rc,
  input  logic                  daz,
  input  logic [LANES*16-1:0]   merge_in,
  output logic [LANES*16-1:0]   res,
  output logic [4:0]            flags
);
  localparam int DW = 64;
  localparam int HW = 16;
  localparam int LW = $clog2(LANES) + 1;

  function automatic logic [20:0] cvt(input logic [63:0] d, input logic [1:0] rm, input logic dz);
    logic s;
    logic [10:0] e;
    logic [51:0] m;
    logic [74:0] t;
    logic [6:0] sh;
    logic [10:0] q;
    logic [10:0] eb;
    logic g, st, inc, inx, ovf;
    logic [15:0] enc;
    logic [4:0] fl;
    logic [15:0] h;
    s = d[63];
    e = d[62:52];
    m = d[51:0];
    fl = '0;
    h = '0;
    ovf = 1'b0;
    t = '0;
    sh = '0;
    q = '0;
    g = 1'b0;
    st = 1'b0;
    inc = 1'b0;
    inx = 1'b0;
    enc = '0;
    eb = '0;
    if (e == 11'h7FF) begin
      if (m == '0) h = {s, 15'h7C00};
      else begin
        h = {s, 5'h1F, 1'b1, m[50:42]};
        fl[0] = ~m[51];
      end
    end else if (e == 11'd0) begin
      if (m == '0) h = {s, 15'h0000};
      else begin
        fl[1] = 1'b1;
        if (dz) h = {s, 15'h0000};
        else begin
          inc = (rm == 2'b10 && !s) || (rm == 2'b01 && s);
          h = {s, 14'h0000, inc};
          fl[3] = 1'b1;
          fl[4] = 1'b1;
        end
      end
    end else if (e > 11'd1038) begin
      ovf = 1'b1;
    end else begin
      if (e >= 11'd1009) sh = 7'd42;
      else if (e < 11'd987) sh = 7'd64;
      else begin
        eb = 11'd1051 - e;
        sh = eb[6:0];
      end
      t = 75'({1'b1, m, 64'b0} >> sh);
      q = t[74:64];
      g = t[63];
      st = |t[62:0];
      inx = g | st;
      case (rm)
        2'b00: inc = g & (st | q[0]);
        2'b01: inc = s & inx;
        2'b10: inc = ~s & inx;
        default: inc = 1'b0;
      endcase
      eb = (e >= 11'd1009) ? (e - 11'd1009) : 11'd0;
      enc = {eb[5:0], 10'b0} + {5'b0, q} + {15'b0, inc};
      if (enc >= 16'h7C00) ovf = 1'b1;
      else begin
        h = {s, enc[14:0]};
        fl[4] = inx;
        fl[3] = inx && (e < 11'd1009);
      end
    end
    if (ovf) begin
      fl[2] = 1'b1;
      fl[4] = 1'b1;
      h = {s, (rm == 2'b00 || (rm == 2'b10 && !s) || (rm == 2'b01 && s)) ? 15'h7C00 : 15'h7BFF};
    end
    return {fl, h};
  endfunction

  logic [1:0] rm_sel;
  logic [LW-1:0] nlanes;
  logic [LANES*HW-1:0] nxt_res;
  logic [4:0] lane_fl [LANES];
  logic [4:0] nxt_fl;

  assign rm_sel = (!src_is_mem && vlen_sel[1] && bcast) ? emb_rc : glob_rc;
  assign nlanes = vlen_sel[1] ? LW'(LANES) : (vlen_sel[0] ? LW'(4) : LW'(2));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [DW-1:0] din;
    logic [20:0] cv;
    logic in_rng, act;
    assign din = (src_is_mem && bcast) ? src[DW-1:0] : src[DW*j +: DW];
    assign cv = cvt(din, rm_sel, daz);
    assign in_rng = LW'(j) < nlanes;
    assign act = in_rng && (!mask_en || lane_mask[j]);
    assign nxt_res[HW*j +: HW] = !in_rng ? '0 : act ? cv[15:0] : zero_mode ? '0 : merge_in[HW*j +: HW];
    assign lane_fl[j] = act ? cv[20:16] : 5'b0;
  end

  always_comb begin
    nxt_fl = '0;
    for (int j = 0; j < LANES; j++) nxt_fl = nxt_fl | lane_fl[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res   <= '0;
      flags <= '0;
    end else begin
      res   <= nxt_res;
      flags <= nxt_fl;
    end
  end
endmodule

// File: rtl/fp64_to_fp16_pack_chk.sv
module fp64_to_fp16_pack_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   vlen_sel,
  input logic [7:0]   lane_mask,
  input logic         mask_en,
  input logic         zero_mode,
  input logic         bcast,
  input logic         src_is_mem,
  input logic [127:0] merge_in,
  input logic [127:0] res,
  input logic [4:0]   flags
);
  AST_UPPER_CLEAR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    vlen_sel == 2'b00 |=> res[127:32] == '0); // R5
  AST_UPPER_CLEAR_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    vlen_sel == 2'b01 |=> res[127:64] == '0); // R5
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && !lane_mask[0] && !zero_mode) |=> res[15:0] == $past(merge_in[15:0])); // R4
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && !lane_mask[0] && zero_mode) |=> res[15:0] == 16'h0000); // R4
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && lane_mask == 8'h00) |=> flags == 5'b0); // R11
  AST_OVF_PREC: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> flags[4]); // R8
  AST_UNF_PREC: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] |-> flags[4]); // R9
  AST_BCAST_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (src_is_mem && bcast && vlen_sel[1] && !mask_en) |=>
      (res[31:16] == res[15:0] && res[127:112] == res[15:0])); // R3
endmodule

bind fp64_to_fp16_pack fp64_to_fp16_pack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vlen_sel(vlen_sel), .lane_mask(lane_mask),
  .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast), .src_is_mem(src_is_mem),
  .merge_in(merge_in), .res(res), .flags(flags)
);

// File: tb/tb_fp64_to_fp16_pack.sv
module tb_fp64_to_fp16_pack;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic [511:0] src;
  logic [1:0]   vlen_sel;
  logic [7:0]   lane_mask;
  logic         mask_en, zero_mode, bcast, src_is_mem, daz;
  logic [1:0]   emb_rc, glob_rc;
  logic [127:0] merge_in;
  logic [127:0] res;
  logic [4:0]   flags;
  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] er;
  logic [4:0]   ef;

  fp64_to_fp16_pack dut (
    .clk(clk), .rst_n(rst_n), .src(src), .vlen_sel(vlen_sel), .lane_mask(lane_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast), .src_is_mem(src_is_mem),
    .emb_rc(emb_rc), .glob_rc(glob_rc), .daz(daz), .merge_in(merge_in),
    .res(res), .flags(flags)
  );

  function automatic logic [63:0] h2d(input logic [15:0] h);
    logic [4:0] e5;
    logic [9:0] m;
    logic [51:0] mm;
    int p;
    e5 = h[14:10];
    m = h[9:0];
    if (e5 == 5'h1F) return {h[15], 11'h7FF, m, 42'b0};
    if (e5 == 5'h00) begin
      if (m == '0) return {h[15], 63'b0};
      p = 0;
      for (int i = 0; i < 10; i++) if (m[i]) p = i;
      mm = 52'(m) << (52 - p);
      return {h[15], 11'(999 + p), mm};
    end
    return {h[15], 11'(e5 + 11'd1008), m, 42'b0};
  endfunction

  task automatic defaults();
    src = '0; vlen_sel = 2'b10; lane_mask = '0; mask_en = 0; zero_mode = 0;
    bcast = 0; src_is_mem = 0; emb_rc = 0; glob_rc = 0; daz = 0; merge_in = '0;
  endtask

  task automatic chk(input logic [127:0] xr, input logic [4:0] xf, input string tag);
    @(posedge clk); #1;
    n_cmp++;
    if (res !== xr) begin n_bad++; $display("FAIL %s res got %h exp %h", tag, res, xr); end
    n_cmp++;
    if (flags !== xf) begin n_bad++; $display("FAIL %s flags got %b exp %b", tag, flags, xf); end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 0;
    src = {8{64'h7FF0_0000_0000_0001}};
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (res !== '0 || flags !== '0) begin n_bad++; $display("FAIL R12 reset got %h/%b exp 0/0", res, flags); end
    @(negedge clk);
    rst_n = 1;
    defaults();

    // R6 R10: every half value round-trips
    for (int g = 0; g < 8192; g++) begin
      er = '0; ef = '0;
      for (int j = 0; j < 8; j++) begin
        logic [15:0] h;
        h = 16'(g * 8 + j);
        src[64*j +: 64] = h2d(h);
        if (h[14:10] == 5'h1F && h[9:0] != 0) begin
          er[16*j +: 16] = h | 16'h0200;
          if (!h[9]) ef[0] = 1'b1;
        end else er[16*j +: 16] = h;
      end
      chk(er, ef, "R6_R10 sweep");
    end

    // R7 R8: rounding sweep around normal values
    for (int rm = 0; rm < 4; rm++) begin
      for (int off = 0; off < 3; off++) begin
        glob_rc = 2'(rm);
        for (int k = 0; k < 3840; k++) begin
          er = '0; ef = '0;
          for (int j = 0; j < 8; j++) begin
            logic [15:0] mag, mr;
            logic [63:0] d;
            logic s, up;
            mag = 16'h0400 + 16'(k * 8 + j);
            s = j[0];
            d = h2d({s, mag[14:0]});
            if (off != 2) d[41] = 1'b1;
            if (off != 0) d[0] = 1'b1;
            case (rm)
              0: up = (off == 0) ? mag[0] : (off == 1);
              1: up = s;
              2: up = ~s;
              default: up = 1'b0;
            endcase
            mr = mag + 16'(up);
            src[64*j +: 64] = d;
            er[16*j +: 16] = {s, mr[14:0]};
            ef[4] = 1'b1;
            if (mr == 16'h7C00) ef[2] = 1'b1;
          end
          chk(er, ef, "R7_R8 round sweep");
        end
      end
    end
    defaults();

    // R9 subnormal inputs
    vlen_sel = 2'b00;
    src[63:0] = 64'h0000_0000_0000_0001; src[127:64] = 64'h8000_0000_0000_0001;
    daz = 1; chk({96'b0, 16'h8000, 16'h0000}, 5'b00010, "R9 daz");
    daz = 0; glob_rc = 2'b10; chk({96'b0, 16'h8000, 16'h0001}, 5'b11010, "R9 up");
    glob_rc = 2'b01; chk({96'b0, 16'h8001, 16'h0000}, 5'b11010, "R9 down");
    src[63:0] = 64'h3E60_0000_0000_0000; src[127:64] = 64'hBE60_0000_0000_0000;
    glob_rc = 2'b00; chk({96'b0, 16'h8000, 16'h0000}, 5'b11000, "R9 tie underflow");
    glob_rc = 2'b10; chk({96'b0, 16'h8000, 16'h0001}, 5'b11000, "R9 underflow up");

    // R8 huge
    src[63:0] = 64'h7FE0_0000_0000_0000; src[127:64] = 64'hFFE0_0000_0000_0000;
    glob_rc = 2'b11; chk({96'b0, 16'hFBFF, 16'h7BFF}, 5'b10100, "R8 toward zero");
    glob_rc = 2'b00; chk({96'b0, 16'hFC00, 16'h7C00}, 5'b10100, "R8 nearest");
    glob_rc = 2'b10; chk({96'b0, 16'hFBFF, 16'h7C00}, 5'b10100, "R8 up");
    defaults();

    // R2 rounding source
    src = {8{64'h3FF0_0200_0000_0001}};
    emb_rc = 2'b11; glob_rc = 2'b00; bcast = 1;
    chk({8{16'h3C00}}, 5'b10000, "R2 embedded used");
    src_is_mem = 1; chk({8{16'h3C01}}, 5'b10000, "R2 memory uses global");
    src_is_mem = 0; vlen_sel = 2'b01; chk({64'b0, {4{16'h3C01}}}, 5'b10000, "R2 short uses global");
    vlen_sel = 2'b10; bcast = 0; chk({8{16'h3C01}}, 5'b10000, "R2 no bit uses global");
    defaults();

    // R3 broadcast
    for (int j = 0; j < 8; j++) src[64*j +: 64] = h2d(16'h3C00 + 16'(j));
    er = '0;
    for (int j = 0; j < 8; j++) er[16*j +: 16] = 16'h3C00 + 16'(j);
    src_is_mem = 1; bcast = 1; chk({8{16'h3C00}}, 5'b0, "R3 memory broadcast");
    src_is_mem = 0; chk(er, 5'b0, "R3 register no broadcast");
    src_is_mem = 1; bcast = 0; chk(er, 5'b0, "R3 memory no broadcast");
    src_is_mem = 0;

    // R1 R5 lane counts, out-of-range lanes silent
    src[64*5 +: 64] = 64'h7FF0_0000_0000_0001;
    vlen_sel = 2'b00; chk({96'b0, er[31:0]}, 5'b0, "R1_R5 two lanes");
    vlen_sel = 2'b01; chk({64'b0, er[63:0]}, 5'b0, "R1_R5 four lanes");
    er[95:80] = 16'h7E00;
    vlen_sel = 2'b11; chk(er, 5'b00001, "R1 eight lanes");

    // R4 R11 masking
    for (int j = 0; j < 8; j++) begin
      src[64*j +: 64] = h2d(16'h4000 + 16'(j));
      merge_in[16*j +: 16] = 16'hA000 + 16'(j);
    end
    src[64*1 +: 64] = 64'h7FF0_0000_0000_0001;
    vlen_sel = 2'b10; mask_en = 1; lane_mask = 8'b1010_0101;
    er = '0;
    for (int j = 0; j < 8; j++) er[16*j +: 16] = lane_mask[j] ? 16'h4000 + 16'(j) : 16'hA000 + 16'(j);
    chk(er, 5'b0, "R4_R11 merge");
    zero_mode = 1;
    for (int j = 0; j < 8; j++) if (!lane_mask[j]) er[16*j +: 16] = 16'h0000;
    chk(er, 5'b0, "R4_R11 zeroing");
    mask_en = 0; lane_mask = 8'h00;
    for (int j = 0; j < 8; j++) er[16*j +: 16] = 16'h4000 + 16'(j);
    er[31:16] = 16'h7E00;
    chk(er, 5'b00001, "R4_R11 mask off");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule